// File: doc/BRIEF.md
# Dual-Width Converter Host Register Interface

This block is the host-facing register front end of a data converter. A parallel host bus with active-low chip select, write strobe and read strobe reaches two registers through it: a 13-bit configuration word that the host can only write, and a 13-bit conversion result that the host can only read. The configuration word goes straight out to the converter core. The result is loaded from the core whenever the core pulses a valid strobe.

One configuration bit picks the bus width. In the wide setting, one write loads the whole configuration word, and one read returns the whole result. In the narrow setting the host moves bytes. A self-clearing flag inside the configuration word steers the next write to the upper part of the word. Reads alternate between the low byte and a sign-extended high byte. A single-ended bit replaces any negative result with zero as it is loaded. The block also drives two output-enable lines, one for the low data pins and one for the upper data pins, so that the pad ring can tri-state whatever is not in use.

Top module: `cnv_hostif`

## Requirements
- R1: After reset the configuration output is 0x0100 and the result register reads as zero. The first narrow read returns the low byte.
- R2: When configuration bit 12 is 1 (wide bus), an access with cs_n, wr_n low loads all 13 configuration bits from wdata[12:0] at the next clock edge.
- R3: When bit 12 is 0 and bit 7 (high-byte flag) is 0, a write loads bits 7..0 from wdata[7:0] and leaves bits 12..8 unchanged.
- R4: When bit 12 is 0 and bit 7 is 1, a write loads bits 12..8 from wdata[4:0] and clears bit 7. Bits 6..0 and wdata[7:5] have no effect on the word.
- R5: The result register changes only on a clock edge where res_valid is 1. A read in the same cycle as res_valid returns the previous result.
- R6: When configuration bit 6 (single-ended) is 1, a loaded result whose bit 12 (sign) is 1 is stored as zero. With bit 6 at 0, negative results are stored unchanged.
- R7: In wide mode a read returns {3'b000, result[12:0]} on rdata and does not alternate.
- R8: In narrow mode successive reads alternate. The first returns {8'h00, result[7:0]}. The second returns {8'h00, sign, sign, sign, result[12:8]}, with the sign in rdata[7:5]. The third returns the low byte again.
- R9: Loading a new result returns the narrow read alternation to the low byte.
- R10: data_oe[0] is 1 only while a read is active, and data_oe[1] only while a read is active in wide mode. rdata is zero when no read is active.
- R11: Write or read strobes with cs_n high change neither the configuration nor the read alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, taken at the clock edge |
| rd_n | input | 1 | Read strobe, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, zero when not reading |
| data_oe | output | 2 | [0] low data pins driven, [1] upper data pins driven |
| res_valid | input | 1 | Converter core result strobe |
| res_word | input | 13 | Converter result, two's complement, bit 12 is the sign |
| cfg_word | output | 13 | Current configuration word to the core |

## Verification
The hardest path to reach is the high-byte flag. It is set by a narrow low-byte write, taken by the next write, and that write can also flip the bus width. The case where a new result lands while the narrow read alternation points at the high byte is just as hard to reach. The vector walk chains writes so that a narrow low write sets the flag, an upper write clears it and switches to wide, and a wide write returns to narrow with single-ended set. It then loads a result after an odd number of narrow reads, to show that the alternation restarts at the low byte. Directed steps follow. They drive strobes without chip select, and they pulse res_valid in the same cycle as a read.

// File: rtl/cnv_hostif_pkg.sv
package cnv_hostif_pkg;
  // configuration bit positions that other logic decodes
  localparam int unsigned BW_BIT  = 12;
  localparam int unsigned HB_BIT  = 7;
  localparam int unsigned SE_BIT  = 6;

  typedef enum logic {
    RP_LOW  = 1'b0,
    RP_HIGH = 1'b1
  } rd_phase_e;
endpackage

// File: rtl/cnv_rst_sync.sv
module cnv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cnv_cfg_store.sv
module cnv_cfg_store #(
  parameter int unsigned REG_W   = 13,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned BW_POS  = 12,
  parameter int unsigned HB_POS  = 7,
  parameter logic [REG_W-1:0] RST_VAL = 13'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wbits,
  output logic [REG_W-1:0] cfg_q
);
  localparam int unsigned UPR_W = REG_W - BYTE_W;

  logic [REG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_q[BW_POS]) begin
      cfg_d = wbits;
    end else if (cfg_q[HB_POS]) begin
      cfg_d[REG_W-1:BYTE_W] = wbits[UPR_W-1:0];
      cfg_d[HB_POS]         = 1'b0;
    end else begin
      cfg_d[BYTE_W-1:0] = wbits[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (wr_hit) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cnv_result_store.sv
module cnv_result_store #(
  parameter int unsigned REG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clamp_neg,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] res_q
);
  logic [REG_W-1:0] res_d;

  always_comb begin
    res_d = din;
    if (clamp_neg && din[REG_W-1]) res_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (load) res_q <= res_d;
  end
endmodule

// File: rtl/cnv_read_fmt.sv
module cnv_read_fmt
  import cnv_hostif_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              wide,
  input  logic              load,
  input  logic [REG_W-1:0]  res_q,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        data_oe
);
  localparam int unsigned UPR_W   = REG_W - BYTE_W;
  localparam int unsigned XPAD_W  = BYTE_W - UPR_W;
  localparam int unsigned WPAD_W  = DATA_W - REG_W;
  localparam int unsigned NHI_W   = DATA_W - BYTE_W;

  rd_phase_e phase_q, phase_d;
  logic      sign;

  assign sign = res_q[REG_W-1];

  always_comb begin
    phase_d = phase_q;
    if (load)                 phase_d = RP_LOW;
    else if (rd_hit && !wide) phase_d = (phase_q == RP_LOW) ? RP_HIGH : RP_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= RP_LOW;
    else        phase_q <= phase_d;
  end

  always_comb begin
    rdata   = '0;
    data_oe = 2'b00;
    if (rd_hit) begin
      data_oe[0] = 1'b1;
      data_oe[1] = wide;
      if (wide)
        rdata = {{WPAD_W{1'b0}}, res_q};
      else if (phase_q == RP_LOW)
        rdata = {{NHI_W{1'b0}}, res_q[BYTE_W-1:0]};
      else
        rdata = {{NHI_W{1'b0}}, {XPAD_W{sign}}, res_q[REG_W-1:BYTE_W]};
    end
  end
endmodule

// File: rtl/cnv_hostif.sv
module cnv_hostif
  import cnv_hostif_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 13,
  parameter int unsigned BYTE_W = 8,
  parameter logic [12:0] CFG_RST = 13'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        data_oe,
  input  logic              res_valid,
  input  logic [REG_W-1:0]  res_word,
  output logic [REG_W-1:0]  cfg_word
);
  logic             rst_sync_n;
  logic             wr_hit;
  logic             rd_hit;
  logic [REG_W-1:0] res_q;
  logic             wdata_unused;

  assign wr_hit       = !cs_n && !wr_n;
  assign rd_hit       = !cs_n && !rd_n;
  assign wdata_unused = ^wdata[DATA_W-1:REG_W];

  cnv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cnv_cfg_store #(
    .REG_W   (REG_W),
    .BYTE_W  (BYTE_W),
    .BW_POS  (BW_BIT),
    .HB_POS  (HB_BIT),
    .RST_VAL (CFG_RST)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_hit (wr_hit),
    .wbits  (wdata[REG_W-1:0]),
    .cfg_q  (cfg_word)
  );

  cnv_result_store #(.REG_W(REG_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (res_valid),
    .clamp_neg (cfg_word[SE_BIT]),
    .din       (res_word),
    .res_q     (res_q)
  );

  cnv_read_fmt #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .BYTE_W (BYTE_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_hit  (rd_hit),
    .wide    (cfg_word[BW_BIT]),
    .load    (res_valid),
    .res_q   (res_q),
    .rdata   (rdata),
    .data_oe (data_oe)
  );
endmodule

// File: rtl/cnv_hostif_chk.sv
module cnv_hostif_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 13
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic [DATA_W-1:0] wdata,
  input logic [1:0]        data_oe,
  input logic              res_valid,
  input logic [REG_W-1:0]  res_word,
  input logic [REG_W-1:0]  res_q,
  input logic [REG_W-1:0]  cfg_word
);
  logic wr_act;
  assign wr_act = !cs_n && !wr_n;

  a_r2_wide_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_act && cfg_word[12]) |=> (cfg_word == $past(wdata[REG_W-1:0])));

  a_r3_low_keeps_upper: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_act && !cfg_word[12] && !cfg_word[7]) |=> $stable(cfg_word[REG_W-1:8]));

  a_r4_flag_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_act && !cfg_word[12] && cfg_word[7]) |=> (!cfg_word[7] && $stable(cfg_word[6:0])));

  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_valid |=> $stable(res_q));

  a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && cfg_word[6] && res_word[REG_W-1]) |=> (res_q == '0));

  a_r10_upper_oe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_oe[1] |-> (data_oe[0] && cfg_word[12]));

  a_r10_idle_oe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n || rd_n) |-> (data_oe == 2'b00));

  a_r11_no_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |=> $stable(cfg_word));
endmodule

bind cnv_hostif cnv_hostif_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .rd_n       (rd_n),
  .wdata      (wdata),
  .data_oe    (data_oe),
  .res_valid  (res_valid),
  .res_word   (res_word),
  .res_q      (res_q),
  .cfg_word   (cfg_word)
);

// File: tb/cnv_hostif_test.sv
`timescale 1ns/1ps
module cnv_hostif_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, wr_n, rd_n;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  data_oe;
  logic        res_valid;
  logic [12:0] res_word;
  logic [12:0] cfg_word;

  int checks = 0;
  int errors = 0;

  logic [15:0] rd_seen;
  logic [1:0]  oe_seen;

  always #10 clk = ~clk;

  cnv_hostif uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .wdata(wdata), .rdata(rdata), .data_oe(data_oe),
    .res_valid(res_valid), .res_word(res_word), .cfg_word(cfg_word)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LD = 2'd2;
  localparam int NVEC = 20;
  // {op, data, expected (cfg_word for writes, rdata for reads), expected data_oe}
  localparam logic [35:0] VEC [NVEC] = '{
    {OP_WR, 16'h0085, 16'h0185, 2'b00}, // R3 low byte, flag set
    {OP_WR, 16'h00F3, 16'h1305, 2'b00}, // R4 upper bits from wdata[4:0], flag cleared
    {OP_WR, 16'hEA4C, 16'h0A4C, 2'b00}, // R2 wide load, back to narrow, single-ended on
    {OP_LD, 16'h1F00, 16'h0000, 2'b00}, // R6 negative clamped
    {OP_RD, 16'h0000, 16'h0000, 2'b01}, // R6 low byte zero
    {OP_RD, 16'h0000, 16'h0000, 2'b01}, // R6 high byte zero
    {OP_WR, 16'h0000, 16'h0A00, 2'b00}, // R3 single-ended off
    {OP_LD, 16'h1ABC, 16'h0000, 2'b00}, // R6 negative kept
    {OP_RD, 16'h0000, 16'h00BC, 2'b01}, // R8 low byte
    {OP_RD, 16'h0000, 16'h00FA, 2'b01}, // R8 high byte sign-extended
    {OP_RD, 16'h0000, 16'h00BC, 2'b01}, // R8 low again
    {OP_LD, 16'h0234, 16'h0000, 2'b00}, // R9 load while phase high
    {OP_RD, 16'h0000, 16'h0034, 2'b01}, // R9 restarts at low byte
    {OP_RD, 16'h0000, 16'h0002, 2'b01}, // R8 positive high byte
    {OP_WR, 16'h0080, 16'h0A80, 2'b00}, // R3 flag set
    {OP_WR, 16'hFFF0, 16'h1000, 2'b00}, // R4 wdata[7:5] ignored, go wide
    {OP_RD, 16'h0000, 16'h0234, 2'b11}, // R7 wide read
    {OP_RD, 16'h0000, 16'h0234, 2'b11}, // R7 no alternation
    {OP_LD, 16'h1800, 16'h0000, 2'b00}, // R6 off: negative kept
    {OP_RD, 16'h0000, 16'h1800, 2'b11}  // R7 wide negative
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample mid-low-phase, release at next negedge
  task automatic bus_op(input logic [1:0] op, input logic [15:0] d, input logic sel);
    @(negedge clk);
    cs_n = ~sel; wdata = d;
    wr_n = (op == OP_WR) ? 1'b0 : 1'b1;
    rd_n = (op == OP_RD) ? 1'b0 : 1'b1;
    res_valid = (op == OP_LD);
    res_word  = d[12:0];
    #5;
    rd_seen = rdata; oe_seen = data_oe;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; res_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    wdata = '0; res_valid = 1'b0; res_word = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cfg", {3'b0, cfg_word}, 16'h0100);
    bus_op(OP_RD, 16'h0, 1'b1);
    chk("R1 read", rd_seen, 16'h0000);
    chk("R1 oe", {14'b0, oe_seen}, 16'h0001);
    bus_op(OP_RD, 16'h0, 1'b1); // realign phase to low

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic [15:0] d, e;
      logic [1:0]  o;
      {op, d, e, o} = VEC[i];
      bus_op(op, d, 1'b1);
      if (op == OP_WR) chk($sformatf("vec%0d cfg", i), {3'b0, cfg_word}, e);
      if (op == OP_RD) begin
        chk($sformatf("vec%0d rdata", i), rd_seen, e);
        chk($sformatf("vec%0d oe", i), {14'b0, oe_seen}, {14'b0, o});
      end
    end

    // R10 idle outputs
    #2;
    chk("R10 idle rdata", rdata, 16'h0000);
    chk("R10 idle oe", {14'b0, data_oe}, 16'h0000);

    // R11 write without chip select (wide mode now)
    bus_op(OP_WR, 16'h0055, 1'b0);
    chk("R11 write ignored", {3'b0, cfg_word}, 16'h1000);

    // R5 result unchanged without valid, and same-cycle read sees old value
    @(negedge clk); res_word = 13'h0777; #5;
    @(negedge clk);
    bus_op(OP_RD, 16'h0, 1'b1);
    chk("R5 no valid", rd_seen, 16'h1800);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; res_valid = 1'b1; res_word = 13'h0321;
    #5 rd_seen = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; res_valid = 1'b0;
    chk("R5 same cycle old", rd_seen, 16'h1800);
    bus_op(OP_RD, 16'h0, 1'b1);
    chk("R5 new value", rd_seen, 16'h0321);

    // back to narrow, then R11 read without select must not advance phase
    bus_op(OP_WR, 16'h0000, 1'b1);
    chk("R2 to narrow", {3'b0, cfg_word}, 16'h0000);
    bus_op(OP_RD, 16'h0, 1'b0);
    chk("R11 unselected read idle", rd_seen, 16'h0000);
    bus_op(OP_RD, 16'h0, 1'b1);
    chk("R11 phase kept low", rd_seen, 16'h0021);
    bus_op(OP_RD, 16'h0, 1'b1);
    chk("R8 high", rd_seen, 16'h0003);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule